// File: doc/BRIEF.md
# Pointer Address Generator with Shadow Bank

This block produces data-memory addresses for a 24-bit address space. It keeps six pointer registers (R0 to R5), a 24-bit primary offset register N, a 16-bit secondary offset register N3 and one 16-bit modifier register M. Each operation names a pointer, an addressing mode and an access size. The block puts the effective address on `ea_o` in the same cycle, combinationally. At the next clock edge it post-updates the pointer through a primary adder.

For dual-read operations a second adder runs in the same cycle. It places R3 on `ea2_o` and advances R3 by the sign-extended N3. The modifier turns post-updates of R0 and R1 into modulo (circular-buffer) arithmetic. All other pointers stay linear.

A hidden bank holds second copies of R0, R1, N and M. A single swap strobe exchanges the two banks. Fast interrupt handlers can use this to get a private set of address registers without saving or restoring anything.

Top module: `agu_ptr_unit`

## Requirements
- R1: A synchronous active-low reset clears R0 to R5, N and N3 to zero and sets M to 0xFFFF. The value 0xFFFF selects linear arithmetic.
- R2: Modes are encoded on `op_mode` as 0 hold, 1 post-step, 2 post-offset, 3 indexed and 4 dual. In modes 0, 1, 2 and 4, `ea_o` equals the selected pointer before any update.
- R3: Post-step (mode 1) adds 1 to the pointer for a word access (`op_long`=0) and 2 for a long access (`op_long`=1).
- R4: Post-offset (mode 2) adds N[15:0], sign-extended to 24 bits, to the pointer. N[23:16] is ignored. The sum wraps modulo 2^24.
- R5: Indexed (mode 3) drives `ea_o` with pointer + N (all 24 bits) for word accesses and pointer + 2·N for long accesses. The pointer is not changed.
- R6: When M is not 0xFFFF, post-updates of R0 and R1 are modulo M+1. The pointer bits above the block mask stay fixed. The block mask is every bit at and below the highest set bit of M. The offset inside the block wraps within 0..M. The step magnitude must not exceed M+1.
- R7: Post-updates of R2 to R5 are linear whatever M holds.
- R8: Dual mode (4) advances the selected pointer as in post-step. In the same cycle it drives `ea2_o` with R3 and adds the sign-extended N3 to R3.
- R9: A swap exchanges R0, R1, N and M with their hidden copies in one cycle, and a second swap restores them. R2 to R5 and N3 are not touched.
- R10: A register write in the same cycle as a swap lands in the working register after the exchange. The hidden copy receives the value the working register had before that edge.
- R11: `wr_sel` selects 0 to 5 for R0 to R5, 6 for N, 7 for N3 and 8 for M. N3 and M take `wr_data[15:0]`. A write wins over a pointer update to the same register in the same cycle.
- R12: Reset clears the hidden copies of R0, R1 and N to zero. The hidden copy of M is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register to write (see R11) |
| wr_data | input | 24 | Write value |
| swap_en | input | 1 | Exchange working and hidden bank |
| op_valid | input | 1 | Address operation present |
| op_mode | input | 3 | Addressing mode (see R2) |
| op_ptr | input | 3 | Pointer index 0 to 5 |
| op_long | input | 1 | Long (double-word) access |
| ea_o | output | 24 | Primary effective address |
| ea2_o | output | 24 | Secondary effective address (R3) |

## Verification
The hardest state to reach from the ports is the one in which the banks have drifted apart. A write has been merged into a swap, and the hidden modifier has been swapped in while uninitialised. The bench reaches it with a fixed sequence. It first fills one bank and swaps. It reads back the reset contents of the hidden copies, then writes M before any modulo use. Finally it issues a write that coincides with a swap and follows it with a restoring swap. A sweep of modulus values 2 to 13, stepping R0 upward and R1 downward past the wrap point, covers the boundary arithmetic.

// File: rtl/agu_pkg.sv
// Shared definitions for the pointer address generator.
// Assumes: mode codes are fixed by the instruction decoder that drives op_mode.
package agu_pkg;
    typedef enum logic [2:0] {
        AGU_HOLD      = 3'd0,
        AGU_POST_STEP = 3'd1,
        AGU_POST_N    = 3'd2,
        AGU_INDEX     = 3'd3,
        AGU_DUAL      = 3'd4
    } agu_mode_e;
endpackage

// File: rtl/agu_offset_fmt.sv
// Forms the primary adder operand from the mode, access size and N.
// Assumes: AW > OW; the post-offset path uses only the low OW bits of N.
module agu_offset_fmt
    import agu_pkg::*;
#(
    parameter int AW = 24,
    parameter int OW = 16
) (
    input  agu_mode_e         mode,
    input  logic              long_acc,
    input  logic [AW-1:0]     n_val,
    output logic [AW-1:0]     step
);
    localparam int EXT = AW - OW;

    // Select and shape the offset for the addressing mode.
    always_comb begin
        case (mode)
            AGU_POST_STEP,
            AGU_DUAL:    step = long_acc ? AW'(2) : AW'(1);
            AGU_POST_N:  step = {{EXT{n_val[OW-1]}}, n_val[OW-1:0]};
            AGU_INDEX:   step = long_acc ? {n_val[AW-2:0], 1'b0} : n_val;
            default:     step = '0;
        endcase
    end
endmodule

// File: rtl/agu_mod_adder.sv
// Adds a signed step to an address, either linearly or modulo mval+1.
// In modulo mode the block is aligned to the next power of two at or
// above mval+1; the address bits above the block mask are kept.
// Assumes: |step| <= mval+1 and the incoming offset lies in 0..mval.
module agu_mod_adder #(
    parameter int AW = 24,
    parameter int OW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] step,
    input  logic [OW-1:0] mval,
    input  logic          mod_en,
    output logic [AW-1:0] sum
);
    localparam int SW  = OW + 2;
    localparam int EXT = AW - OW;

    logic [OW-1:0]        mask;
    logic signed [SW-1:0] off_s;
    logic signed [SW-1:0] step_s;
    logic signed [SW-1:0] raw_s;
    logic signed [SW-1:0] lim_s;
    logic signed [SW-1:0] wrap_s;

    // Smear the highest set bit of the modifier downward into a mask.
    always_comb begin
        mask[OW-1] = mval[OW-1];
        for (int b = OW - 2; b >= 0; b--) begin
            mask[b] = mask[b+1] | mval[b];
        end
    end

    // Offset inside the block plus step, folded back once into 0..mval.
    always_comb begin
        off_s  = $signed({2'b00, addr[OW-1:0] & mask});
        step_s = $signed(step[SW-1:0]);
        lim_s  = $signed({2'b00, mval});
        raw_s  = off_s + step_s;
        if (raw_s > lim_s) begin
            wrap_s = raw_s - lim_s - SW'(1);
        end else if (raw_s < 0) begin
            wrap_s = raw_s + lim_s + SW'(1);
        end else begin
            wrap_s = raw_s;
        end
    end

    // Choose between the linear sum and the block-preserving modulo sum.
    always_comb begin
        if (mod_en) begin
            sum = (addr & ~{{EXT{1'b0}}, mask}) | {{EXT{1'b0}}, wrap_s[OW-1:0]};
        end else begin
            sum = addr + step;
        end
    end
endmodule

// File: rtl/agu_regfile.sv
// Pointer, offset and modifier registers with a hidden bank for the
// first NSH pointers, N and M. Priority on a working register, lowest
// first: hold, swap-in, primary update, secondary update, write.
// Assumes: NPTR >= 4 (R3 is the secondary pointer); hidden M has no reset.
module agu_regfile #(
    parameter int AW   = 24,
    parameter int OW   = 16,
    parameter int NPTR = 6,
    parameter int NSH  = 2,
    parameter int SEC  = 3,
    parameter int SELW = 4,
    parameter int PW   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SELW-1:0]      wr_sel,
    input  logic [AW-1:0]        wr_data,
    input  logic                 swap_en,
    input  logic                 upd_en,
    input  logic [PW-1:0]        upd_idx,
    input  logic [AW-1:0]        upd_val,
    input  logic                 sec_en,
    input  logic [AW-1:0]        sec_val,
    output logic [NPTR-1:0][AW-1:0] ptr_q,
    output logic [AW-1:0]        n_q,
    output logic [OW-1:0]        n3_q,
    output logic [OW-1:0]        m_q
);
    localparam logic [SELW-1:0] SEL_N  = SELW'(NPTR);
    localparam logic [SELW-1:0] SEL_N3 = SELW'(NPTR + 1);
    localparam logic [SELW-1:0] SEL_M  = SELW'(NPTR + 2);

    logic [AW-1:0] sh_n;
    logic [OW-1:0] sh_m;

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        logic [AW-1:0] q;
        logic [AW-1:0] swap_val;
        logic [AW-1:0] nxt;

        if (i < NSH) begin : g_shadow
            logic [AW-1:0] sh_q;
            // Hidden copy takes the pre-edge working value on a swap.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_q <= '0;
                end else if (swap_en) begin
                    sh_q <= q;
                end
            end
            assign swap_val = swap_en ? sh_q : q;
        end else begin : g_plain
            assign swap_val = q;
        end

        // Resolve the next working value by priority.
        always_comb begin
            nxt = swap_val;
            if (upd_en && upd_idx == PW'(i)) nxt = upd_val;
            if (sec_en && i == SEC)          nxt = sec_val;
            if (wr_en && wr_sel == SELW'(i)) nxt = wr_data;
        end

        // Working pointer register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= nxt;
            end
        end

        assign ptr_q[i] = q;
    end

    // Working N register: swap, then write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= '0;
        end else if (wr_en && wr_sel == SEL_N) begin
            n_q <= wr_data;
        end else if (swap_en) begin
            n_q <= sh_n;
        end
    end

    // Hidden N copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_n <= '0;
        end else if (swap_en) begin
            sh_n <= n_q;
        end
    end

    // Working modifier: reset to linear, swap, then write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '1;
        end else if (wr_en && wr_sel == SEL_M) begin
            m_q <= wr_data[OW-1:0];
        end else if (swap_en) begin
            m_q <= sh_m;
        end
    end

    // Hidden modifier copy: deliberately left without reset.
    always_ff @(posedge clk) begin
        if (swap_en) begin
            sh_m <= m_q;
        end
    end

    // Secondary offset register, not part of the hidden bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n3_q <= '0;
        end else if (wr_en && wr_sel == SEL_N3) begin
            n3_q <= wr_data[OW-1:0];
        end
    end
endmodule

// File: rtl/agu_ptr_unit.sv
// Top of the pointer address generator. Effective addresses are
// combinational from the current registers; pointer updates land on the
// next clock edge. Modulo arithmetic applies to post-updates of the
// first NMOD pointers only; indexed addresses are always linear.
// Assumes: op_ptr < NPTR; decode keeps |step| within the modulus.
module agu_ptr_unit
    import agu_pkg::*;
#(
    parameter int AW   = 24,
    parameter int OW   = 16,
    parameter int NPTR = 6,
    localparam int SELW = $clog2(NPTR + 3),
    localparam int PW   = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_data,
    input  logic            swap_en,
    input  logic            op_valid,
    input  logic [2:0]      op_mode,
    input  logic [PW-1:0]   op_ptr,
    input  logic            op_long,
    output logic [AW-1:0]   ea_o,
    output logic [AW-1:0]   ea2_o
);
    localparam int NMOD = 2;
    localparam int SEC  = 3;
    localparam int EXT  = AW - OW;

    agu_mode_e               mode;
    logic [NPTR-1:0][AW-1:0] ptr_bank;
    logic [AW-1:0]           n_q;
    logic [OW-1:0]           n3_q;
    logic [OW-1:0]           mod_q;
    logic [AW-1:0]           sel_ptr;
    logic [AW-1:0]           prim_step;
    logic [AW-1:0]           prim_sum;
    logic [AW-1:0]           sec_step;
    logic [AW-1:0]           sec_sum;
    logic                    prim_upd;
    logic                    sec_upd;
    logic                    mod_en;

    assign mode    = agu_mode_e'(op_mode);
    assign sel_ptr = ptr_bank[op_ptr];

    // Decide which adders write back and whether modulo applies.
    always_comb begin
        prim_upd = op_valid && (mode == AGU_POST_STEP || mode == AGU_POST_N ||
                                mode == AGU_DUAL);
        sec_upd  = op_valid && (mode == AGU_DUAL);
        mod_en   = prim_upd && (op_ptr < PW'(NMOD)) && (mod_q != '1);
    end

    assign sec_step = {{EXT{n3_q[OW-1]}}, n3_q};

    agu_offset_fmt #(.AW(AW), .OW(OW)) u_ofs (
        .mode     (mode),
        .long_acc (op_long),
        .n_val    (n_q),
        .step     (prim_step)
    );

    agu_mod_adder #(.AW(AW), .OW(OW)) u_prim (
        .addr   (sel_ptr),
        .step   (prim_step),
        .mval   (mod_q),
        .mod_en (mod_en),
        .sum    (prim_sum)
    );

    agu_mod_adder #(.AW(AW), .OW(OW)) u_sec (
        .addr   (ptr_bank[SEC]),
        .step   (sec_step),
        .mval   (mod_q),
        .mod_en (1'b0),
        .sum    (sec_sum)
    );

    agu_regfile #(
        .AW(AW), .OW(OW), .NPTR(NPTR), .NSH(NMOD), .SEC(SEC),
        .SELW(SELW), .PW(PW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .swap_en (swap_en),
        .upd_en  (prim_upd),
        .upd_idx (op_ptr),
        .upd_val (prim_sum),
        .sec_en  (sec_upd),
        .sec_val (sec_sum),
        .ptr_q   (ptr_bank),
        .n_q     (n_q),
        .n3_q    (n3_q),
        .m_q     (mod_q)
    );

    // Indexed mode presents the sum; every other mode the pre-update pointer.
    assign ea_o  = (op_valid && mode == AGU_INDEX) ? prim_sum : sel_ptr;
    assign ea2_o = ptr_bank[SEC];
endmodule

// File: rtl/agu_ptr_unit_chk.sv
// Property checker for agu_ptr_unit, attached by bind to its internals.
// Assumes: default parameter relations (R3 is the secondary pointer).
module agu_ptr_unit_chk #(
    parameter int AW   = 24,
    parameter int OW   = 16,
    parameter int NPTR = 6,
    parameter int SELW = 4,
    parameter int PW   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [SELW-1:0]         wr_sel,
    input logic [AW-1:0]           wr_data,
    input logic                    swap_en,
    input logic                    op_valid,
    input logic [2:0]              op_mode,
    input logic [PW-1:0]           op_ptr,
    input logic                    op_long,
    input logic [AW-1:0]           ea_o,
    input logic [NPTR-1:0][AW-1:0] ptr_q,
    input logic [OW-1:0]           n3_q,
    input logic [OW-1:0]           m_q
);
    localparam int EXT = AW - OW;

    logic [OW-1:0] blk_mask;
    logic [AW-1:0] r0_high;
    logic [AW-1:0] r3_next;
    logic          quiet;

    // Independent block mask and helper terms for the properties.
    always_comb begin
        blk_mask = '0;
        for (int b = 0; b < OW; b++) begin
            if ((m_q >> b) != '0) blk_mask[b] = 1'b1;
        end
        r0_high = ptr_q[0] & ~{{EXT{1'b0}}, blk_mask};
        r3_next = ptr_q[3] + {{EXT{n3_q[OW-1]}}, n3_q};
        quiet   = !wr_en && !op_valid;
    end

    assert_linear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> m_q == {OW{1'b1}});

    assert_post_ea_is_pointer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_mode == 3'd1 || op_mode == 3'd2 || op_mode == 3'd4))
        |-> ea_o == ptr_q[op_ptr]);

    assert_index_keeps_pointers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode == 3'd3 && !wr_en && !swap_en) |=> $stable(ptr_q));

    assert_modulo_stays_in_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode == 3'd1 && op_ptr == '0 && !op_long && !wr_en &&
         !swap_en && m_q != {OW{1'b1}} && (ptr_q[0][OW-1:0] & blk_mask) <= m_q)
        |=> (r0_high == $past(r0_high)) && ((ptr_q[0][OW-1:0] & blk_mask) <= m_q));

    assert_dual_advances_r3_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode == 3'd4 && !(wr_en && wr_sel == SELW'(3)))
        |=> ptr_q[3] == $past(r3_next));

    assert_double_swap_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && quiet) ##1 (swap_en && quiet) |=> ptr_q[0] == $past(ptr_q[0], 2));

    assert_write_after_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && swap_en && wr_sel == '0) |=> ptr_q[0] == $past(wr_data));
endmodule

bind agu_ptr_unit agu_ptr_unit_chk #(
    .AW(AW), .OW(OW), .NPTR(NPTR), .SELW(SELW), .PW(PW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .swap_en  (swap_en),
    .op_valid (op_valid),
    .op_mode  (op_mode),
    .op_ptr   (op_ptr),
    .op_long  (op_long),
    .ea_o     (ea_o),
    .ptr_q    (ptr_bank),
    .n3_q     (n3_q),
    .m_q      (mod_q)
);

// File: tb/agu_ptr_unit_bench.sv
// Self-checking bench: directed sequences plus a modulus sweep.
module agu_ptr_unit_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [2:0] MD_HOLD = 3'd0;
    localparam logic [2:0] MD_STEP = 3'd1;
    localparam logic [2:0] MD_PN   = 3'd2;
    localparam logic [2:0] MD_IDX  = 3'd3;
    localparam logic [2:0] MD_DUAL = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [23:0] wr_data = '0;
    logic        swap_en = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_mode = '0;
    logic [2:0]  op_ptr = '0;
    logic        op_long = 1'b0;
    logic [23:0] ea_o;
    logic [23:0] ea2_o;

    logic [23:0] got_ea;
    logic [23:0] got_ea2;
    logic [23:0] exp_ptr [6];
    int checks = 0;
    int fails  = 0;

    agu_ptr_unit u_agu_ptr_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .swap_en(swap_en), .op_valid(op_valid),
        .op_mode(op_mode), .op_ptr(op_ptr), .op_long(op_long),
        .ea_o(ea_o), .ea2_o(ea2_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, sample, then idle.
    task automatic cyc(input logic we, input logic [3:0] sel, input logic [23:0] d,
                       input logic sw, input logic ov, input logic [2:0] md,
                       input logic [2:0] p, input logic lg);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; swap_en = sw;
        op_valid = ov; op_mode = md; op_ptr = p; op_long = lg;
        #2;
        got_ea = ea_o;
        got_ea2 = ea2_o;
        @(posedge clk);
        #1;
        wr_en = 1'b0; swap_en = 1'b0; op_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [23:0] d);
        cyc(1'b1, sel, d, 1'b0, 1'b0, MD_HOLD, 3'd0, 1'b0);
    endtask

    task automatic op(input logic [2:0] md, input logic [2:0] p, input logic lg);
        cyc(1'b0, 4'd0, 24'd0, 1'b0, 1'b1, md, p, lg);
    endtask

    task automatic peek(input logic [2:0] p);
        op(MD_HOLD, p, 1'b0);
    endtask

    task automatic swap();
        cyc(1'b0, 4'd0, 24'd0, 1'b1, 1'b0, MD_HOLD, 3'd0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int off;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values; linear step proves M came up as 0xFFFF
        for (int p = 0; p < 6; p++) begin
            peek(3'(p));
            chk("R1 reset pointer", got_ea, 24'h0);
        end
        op(MD_IDX, 3'd0, 1'b0);
        chk("R1 reset N", got_ea, 24'h0);
        wr(4'd0, 24'h00FFFF);
        op(MD_STEP, 3'd0, 1'b0);
        peek(3'd0);
        chk("R1 linear after reset", got_ea, 24'h010000);

        // R3 / R11: word and long post-step on every pointer
        for (int p = 0; p < 6; p++) begin
            exp_ptr[p] = 24'(p * 24'h100000 + 24'h001230);
            wr(4'(p), exp_ptr[p]);
            op(MD_STEP, 3'(p), 1'b0);
            chk("R2 ea before step", got_ea, exp_ptr[p]);
            op(MD_STEP, 3'(p), 1'b1);
            chk("R3 word step", got_ea, exp_ptr[p] + 24'd1);
            exp_ptr[p] = exp_ptr[p] + 24'd3;
            peek(3'(p));
            chk("R3 long step", got_ea, exp_ptr[p]);
        end

        // R4: only N[15:0] sign-extended is used for post-offset
        wr(4'd6, 24'hABFFFE);
        for (int p = 0; p < 6; p++) begin
            op(MD_PN, 3'(p), 1'b0);
            chk("R2 ea before offset", got_ea, exp_ptr[p]);
            exp_ptr[p] = exp_ptr[p] - 24'd2;
            peek(3'(p));
            chk("R4 post offset", got_ea, exp_ptr[p]);
        end
        wr(4'd5, 24'h000001);
        op(MD_PN, 3'd5, 1'b0);
        peek(3'd5);
        chk("R4 wrap below zero", got_ea, 24'hFFFFFF);
        exp_ptr[5] = 24'hFFFFFF;

        // R5: indexed word and long, pointer untouched
        wr(4'd6, 24'h012345);
        for (int p = 0; p < 6; p++) begin
            op(MD_IDX, 3'(p), 1'b0);
            chk("R5 indexed word", got_ea, exp_ptr[p] + 24'h012345);
            op(MD_IDX, 3'(p), 1'b1);
            chk("R5 indexed long", got_ea, exp_ptr[p] + 24'h02468A);
            peek(3'(p));
            chk("R5 pointer kept", got_ea, exp_ptr[p]);
        end

        // R6: modulus sweep, R0 upward and R1 downward
        wr(4'd6, 24'h00FFFF);
        for (int m = 1; m <= 12; m++) begin
            wr(4'd8, 24'(m));
            wr(4'd0, 24'h0003C0);
            wr(4'd1, 24'h0005C0);
            off = 0;
            for (int k = 0; k < m + 3; k++) begin
                op(MD_STEP, 3'd0, 1'b0);
                chk("R6 modulo up", got_ea, 24'h0003C0 + 24'(off));
                off = (off + 1) % (m + 1);
            end
            peek(3'd0);
            chk("R6 modulo up final", got_ea, 24'h0003C0 + 24'(off));
            off = 0;
            for (int k = 0; k < m + 3; k++) begin
                op(MD_PN, 3'd1, 1'b0);
                chk("R6 modulo down", got_ea, 24'h0005C0 + 24'(off));
                off = (off + m) % (m + 1);
            end
        end

        // R7: R2 stays linear where R0 wraps under the same modifier
        wr(4'd8, 24'h000005);
        wr(4'd2, 24'h0003C5);
        wr(4'd0, 24'h0003C5);
        op(MD_STEP, 3'd2, 1'b0);
        op(MD_STEP, 3'd0, 1'b0);
        peek(3'd2);
        chk("R7 linear R2", got_ea, 24'h0003C6);
        peek(3'd0);
        chk("R6 wrap at top", got_ea, 24'h0003C0);
        wr(4'd8, 24'h00FFFF);

        // R8: dual read, secondary adder on R3 with N3
        wr(4'd3, 24'h000100);
        wr(4'd7, 24'h12FFFC);
        wr(4'd0, 24'h000500);
        op(MD_DUAL, 3'd0, 1'b0);
        chk("R8 primary ea", got_ea, 24'h000500);
        chk("R8 secondary ea", got_ea2, 24'h000100);
        op(MD_DUAL, 3'd0, 1'b1);
        chk("R8 primary ea 2", got_ea, 24'h000501);
        chk("R8 secondary ea 2", got_ea2, 24'h0000FC);
        peek(3'd0);
        chk("R8 primary after", got_ea, 24'h000503);
        peek(3'd3);
        chk("R8 R3 after", got_ea, 24'h0000F8);

        // R11: write wins over a same-cycle update of the same pointer
        cyc(1'b1, 4'd2, 24'h777777, 1'b0, 1'b1, MD_STEP, 3'd2, 1'b0);
        peek(3'd2);
        chk("R11 write over update", got_ea, 24'h777777);

        // R9 / R12: bank exchange
        wr(4'd0, 24'h111111);
        wr(4'd1, 24'h222222);
        wr(4'd6, 24'h000333);
        wr(4'd8, 24'h000007);
        wr(4'd4, 24'h444444);
        swap();
        peek(3'd0);
        chk("R12 hidden R0 reset", got_ea, 24'h0);
        peek(3'd1);
        chk("R12 hidden R1 reset", got_ea, 24'h0);
        op(MD_IDX, 3'd0, 1'b0);
        chk("R12 hidden N reset", got_ea, 24'h0);
        peek(3'd4);
        chk("R9 R4 not swapped", got_ea, 24'h444444);
        peek(3'd2);
        chk("R9 R2 not swapped", got_ea, 24'h777777);
        wr(4'd8, 24'h00FFFF);
        wr(4'd0, 24'h0AAAAA);
        swap();
        peek(3'd0);
        chk("R9 R0 restored", got_ea, 24'h111111);
        peek(3'd1);
        chk("R9 R1 restored", got_ea, 24'h222222);
        op(MD_IDX, 3'd1, 1'b0);
        chk("R9 N restored", got_ea, 24'h222555);
        op(MD_STEP, 3'd0, 1'b0);
        peek(3'd0);
        chk("R9 M restored", got_ea, 24'h111112);

        // R10: write merged with a swap
        cyc(1'b1, 4'd0, 24'h0BBBBB, 1'b1, 1'b0, MD_HOLD, 3'd0, 1'b0);
        peek(3'd0);
        chk("R10 write after swap", got_ea, 24'h0BBBBB);
        peek(3'd1);
        chk("R10 R1 swapped", got_ea, 24'h0);
        swap();
        peek(3'd0);
        chk("R10 hidden got old", got_ea, 24'h111112);
        peek(3'd1);
        chk("R10 R1 back", got_ea, 24'h222222);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule